// File: doc/BRIEF.md
# Descriptor Queue and Fragmenter

This block is the ingress stage of one DMA channel. It takes wide transfer descriptors from a descriptor controller over a valid/ready stream with zero ready latency. It keeps up to four of them in a small queue. It then cuts the descriptor at the head of the queue into sub-descriptors whose payload is at most 512 bytes. These are presented one at a time on a valid/ready stream toward a downstream scheduler.

Each sub-descriptor carries:
- the source and destination addresses, advanced for its position within the transfer;
- its own byte count;
- the priority flag of its parent;
- an optional function number;
- the parent ID;
- a sub-ID that places the fragment in an eight-wide window reserved for that parent;
- a flag marking the final piece.

A descriptor leaves the queue only when its final fragment is taken. The ready output therefore reflects how many transfers are still owned by the channel.

Top module: `desc_frag_queue`

## Requirements
- R1: A descriptor is captured on a rising clock edge where `in_valid` and `in_ready` are both high. A descriptor counts as held from its capture until its final fragment is accepted downstream. `in_ready` is low exactly while four descriptors are held, and a word offered while `in_ready` is low is not captured.
- R2: Every fragment except the last carries a length of exactly 512. The last carries the remaining byte count (1 to 512 for a non-zero length).
- R3: A descriptor length above 4096 is treated as 4096, so a descriptor never yields more than eight fragments.
- R4: The sub-ID of fragment k (k counted from 0) of a descriptor with ID n is (n mod 32)*8 + k. `out_id` carries n unchanged.
- R5: Fragment k carries source and destination addresses equal to the descriptor's addresses plus k*512.
- R6: `out_last` is high only on the final fragment of a descriptor. Every fragment copies the priority flag from input bit 160. With HAS_FUNC=1 every fragment also copies the function number from input bits [168:161]; with HAS_FUNC=0 `out_func` is zero.
- R7: A descriptor of length zero produces exactly one fragment, with length zero and `out_last` high.
- R8: While `out_valid` is high and `out_ready` is low, all fragment outputs hold steady. Fragments leave in index order, and descriptors in the order they were captured.
- R9: Reset is synchronous and active low. It empties the queue and abandons any partly split descriptor, so the next descriptor starts again at fragment 0.
- R10: The input word carries the source address in bits [63:0], the destination address in [127:64], the byte length in [145:128] and the descriptor ID in [153:146]. Bits [159:154] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_data | input | IN_W (161 or 169) | Descriptor word with priority and optional function number |
| in_valid | input | 1 | Descriptor word is valid |
| in_ready | output | 1 | Queue can take a descriptor this cycle |
| out_valid | output | 1 | A fragment is presented |
| out_ready | input | 1 | Downstream takes the fragment |
| out_prio | output | 1 | Priority flag of the parent |
| out_func | output | 8 | Function number of the parent, zero when HAS_FUNC=0 |
| out_id | output | 8 | Parent descriptor ID |
| out_sub_id | output | 8 | Sub-ID of this fragment |
| out_src | output | 64 | Source address of this fragment |
| out_dst | output | 64 | Destination address of this fragment |
| out_len | output | FRAG_LOG2+1 | Byte count of this fragment |
| out_last | output | 1 | Final fragment of the parent |

## Verification
Capturing a new descriptor and retiring the head descriptor's final fragment can happen on the same clock edge. The queue count must then stay unchanged, and the read and write slots must both move. The bench provokes this by streaming six single-fragment descriptors while the downstream side is always ready, with the producer and consumer running in parallel. A full-queue case is also run with the consumer stalled and a fifth word held on the input. Results are judged at the ports: every fragment must appear with the expected ID, sub-ID, addresses and length, in capture order, with none lost or duplicated. Alongside this, an occupancy count kept from the two handshakes must always agree with `in_ready`.

// File: rtl/dfq_pkg.sv
package dfq_pkg;

    localparam int ADDR_W   = 64;
    localparam int LEN_W    = 18;
    localparam int ID_W     = 8;
    localparam int FUNC_W   = 8;
    localparam int DESC_W   = 160;

    localparam int SRC_LSB  = 0;
    localparam int DST_LSB  = SRC_LSB + ADDR_W;
    localparam int LEN_LSB  = DST_LSB + ADDR_W;
    localparam int ID_LSB   = LEN_LSB + LEN_W;
    localparam int PRIO_BIT = DESC_W;
    localparam int FUNC_LSB = DESC_W + 1;

    typedef struct packed {
        logic              prio;
        logic [FUNC_W-1:0] func;
        logic [ID_W-1:0]   id;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] dst;
        logic [ADDR_W-1:0] src;
    } desc_t;

endpackage

// File: rtl/dfq_store.sv
module dfq_store
    import dfq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push,
    input  desc_t push_data,
    input  logic  pop,
    output desc_t head,
    output logic  empty,
    output logic  full
);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } ctl_t;

    ctl_t  ctl_q, ctl_d;
    desc_t mem_q [DEPTH];
    desc_t mem_d [DEPTH];
    logic  push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) begin
            return '0;
        end
        return p + 1'b1;
    endfunction

    always_comb begin
        ctl_d   = ctl_q;
        mem_d   = mem_q;
        empty   = (ctl_q.cnt == '0);
        full    = (ctl_q.cnt == CNT_W'(DEPTH));
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        if (push_ok) begin
            mem_d[ctl_q.wr] = push_data;
            ctl_d.wr        = ptr_next(ctl_q.wr);
        end
        if (pop_ok) begin
            ctl_d.rd = ptr_next(ctl_q.rd);
        end
        case ({push_ok, pop_ok})
            2'b10:   ctl_d.cnt = ctl_q.cnt + 1'b1;
            2'b01:   ctl_d.cnt = ctl_q.cnt - 1'b1;
            default: ctl_d.cnt = ctl_q.cnt;
        endcase
        head = mem_q[ctl_q.rd];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

endmodule

// File: rtl/dfq_splitter.sv
module dfq_splitter
    import dfq_pkg::*;
#(
    parameter int FRAG_LOG2 = 9,
    parameter int FIDX_W    = 3,
    localparam int FLEN_W   = FRAG_LOG2 + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  desc_t             head,
    input  logic              head_valid,
    input  logic              out_ready,
    output logic              out_valid,
    output logic              out_prio,
    output logic [FUNC_W-1:0] out_func,
    output logic [ID_W-1:0]   out_id,
    output logic [ID_W-1:0]   out_sub_id,
    output logic [ADDR_W-1:0] out_src,
    output logic [ADDR_W-1:0] out_dst,
    output logic [FLEN_W-1:0] out_len,
    output logic              out_last,
    output logic              retire
);

    localparam int FRAG_BYTES = 1 << FRAG_LOG2;
    localparam int MAX_LEN    = FRAG_BYTES << FIDX_W;
    localparam int KEEP_W     = ID_W - FIDX_W;

    typedef struct packed {
        logic [FIDX_W-1:0] idx;
    } st_t;

    st_t              st_q, st_d;
    logic [LEN_W-1:0] clip_len;
    logic [LEN_W-1:0] offset;
    logic [LEN_W-1:0] remain;
    logic             handshake;

    always_comb begin
        st_d       = st_q;
        clip_len   = (head.len > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : head.len;
        offset     = LEN_W'(st_q.idx) << FRAG_LOG2;
        remain     = clip_len - offset;
        out_last   = (remain <= LEN_W'(FRAG_BYTES));
        out_len    = out_last ? remain[FLEN_W-1:0] : FLEN_W'(FRAG_BYTES);
        out_src    = head.src + ADDR_W'(offset);
        out_dst    = head.dst + ADDR_W'(offset);
        out_sub_id = {head.id[KEEP_W-1:0], st_q.idx};
        out_id     = head.id;
        out_prio   = head.prio;
        out_func   = head.func;
        out_valid  = head_valid;
        handshake  = head_valid && out_ready;
        retire     = handshake && out_last;
        if (handshake) begin
            st_d.idx = out_last ? '0 : st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/desc_frag_queue.sv
module desc_frag_queue
    import dfq_pkg::*;
#(
    parameter int HAS_FUNC  = 0,
    parameter int DEPTH     = 4,
    parameter int FRAG_LOG2 = 9,
    parameter int FIDX_W    = 3,
    localparam int IN_W     = DESC_W + 1 + (HAS_FUNC != 0 ? FUNC_W : 0),
    localparam int FLEN_W   = FRAG_LOG2 + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IN_W-1:0]   in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_prio,
    output logic [FUNC_W-1:0] out_func,
    output logic [ID_W-1:0]   out_id,
    output logic [ID_W-1:0]   out_sub_id,
    output logic [ADDR_W-1:0] out_src,
    output logic [ADDR_W-1:0] out_dst,
    output logic [FLEN_W-1:0] out_len,
    output logic              out_last
);

    desc_t             in_desc;
    desc_t             head;
    logic              empty, full, retire;
    logic [FUNC_W-1:0] in_func;

    if (HAS_FUNC != 0) begin : g_func
        assign in_func = in_data[FUNC_LSB +: FUNC_W];
    end else begin : g_nofunc
        assign in_func = '0;
    end

    always_comb begin
        in_desc.src  = in_data[SRC_LSB +: ADDR_W];
        in_desc.dst  = in_data[DST_LSB +: ADDR_W];
        in_desc.len  = in_data[LEN_LSB +: LEN_W];
        in_desc.id   = in_data[ID_LSB +: ID_W];
        in_desc.prio = in_data[PRIO_BIT];
        in_desc.func = in_func;
        in_ready     = !full;
    end

    dfq_store #(
        .DEPTH (DEPTH)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (in_valid && in_ready),
        .push_data (in_desc),
        .pop       (retire),
        .head      (head),
        .empty     (empty),
        .full      (full)
    );

    dfq_splitter #(
        .FRAG_LOG2 (FRAG_LOG2),
        .FIDX_W    (FIDX_W)
    ) u_split (
        .clk        (clk),
        .rst_n      (rst_n),
        .head       (head),
        .head_valid (!empty),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_prio   (out_prio),
        .out_func   (out_func),
        .out_id     (out_id),
        .out_sub_id (out_sub_id),
        .out_src    (out_src),
        .out_dst    (out_dst),
        .out_len    (out_len),
        .out_last   (out_last),
        .retire     (retire)
    );

endmodule

// File: rtl/dfq_checker.sv
module dfq_checker #(
    parameter int DEPTH     = 4,
    parameter int FRAG_LOG2 = 9,
    localparam int CNT_W    = $clog2(DEPTH + 1),
    localparam int FLEN_W   = FRAG_LOG2 + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic              out_last,
    input logic [FLEN_W-1:0] out_len,
    input logic [7:0]        out_sub_id,
    input logic [63:0]       out_src,
    input logic [63:0]       out_dst
);

    localparam int FRAG_BYTES = 1 << FRAG_LOG2;

    logic [CNT_W-1:0] occ_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= '0;
        end else begin
            case ({in_valid && in_ready, out_valid && out_ready && out_last})
                2'b10:   occ_q <= occ_q + 1'b1;
                2'b01:   occ_q <= occ_q - 1'b1;
                default: occ_q <= occ_q;
            endcase
        end
    end

    AST_READY_OCC: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready == (occ_q != CNT_W'(DEPTH)));  // R1

    AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == '0) |-> !out_valid);  // R1

    AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_len <= FLEN_W'(FRAG_BYTES)));  // R2

    AST_MID_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |-> (out_len == FLEN_W'(FRAG_BYTES)));  // R2

    AST_SUBID_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last) |=>
        (out_valid && out_sub_id == $past(out_sub_id) + 8'd1));  // R4

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last) |=>
        (out_src == $past(out_src) + 64'(FRAG_BYTES) &&
         out_dst == $past(out_dst) + 64'(FRAG_BYTES)));  // R5

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
        (out_valid && $stable(out_sub_id) && $stable(out_src) &&
         $stable(out_len) && $stable(out_last)));  // R8

endmodule

bind desc_frag_queue dfq_checker #(
    .DEPTH     (DEPTH),
    .FRAG_LOG2 (FRAG_LOG2)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_last   (out_last),
    .out_len    (out_len),
    .out_sub_id (out_sub_id),
    .out_src    (out_src),
    .out_dst    (out_dst)
);

// File: tb/desc_frag_queue_tb.sv
`timescale 1ns/1ps
module desc_frag_queue_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [168:0] in_data = '0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic         out_prio;
    logic [7:0]   out_func;
    logic [7:0]   out_id;
    logic [7:0]   out_sub_id;
    logic [63:0]  out_src;
    logic [63:0]  out_dst;
    logic [9:0]   out_len;
    logic         out_last;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    desc_frag_queue #(
        .HAS_FUNC (1)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_data    (in_data),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_prio   (out_prio),
        .out_func   (out_func),
        .out_id     (out_id),
        .out_sub_id (out_sub_id),
        .out_src    (out_src),
        .out_dst    (out_dst),
        .out_len    (out_len),
        .out_last   (out_last)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [168:0] mk(input logic [63:0] src, input logic [63:0] dst,
                                        input int len, input logic [7:0] id,
                                        input logic prio, input logic [7:0] func);
        logic [168:0] w;
        w            = '0;
        w[63:0]      = src;
        w[127:64]    = dst;
        w[145:128]   = 18'(len);
        w[153:146]   = id;
        w[159:154]   = 6'h3f;
        w[160]       = prio;
        w[168:161]   = func;
        return w;
    endfunction

    // called at a negedge; returns at the negedge after capture
    task automatic push(input logic [168:0] w);
        in_data  = w;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_valid();
        int n = 0;
        while (!out_valid && n < 64) begin
            @(negedge clk);
            n++;
        end
        if (!out_valid) chk(1'b0, "R8", "out_valid timeout", 64'(out_valid), 64'd1);
    endtask

    task automatic expect_desc(input logic [63:0] src, input logic [63:0] dst,
                               input int len, input logic [7:0] id,
                               input logic prio, input logic [7:0] func);
        int clip = (len > 4096) ? 4096 : len;
        int nfr  = (clip == 0) ? 1 : (clip + 511) / 512;
        out_ready = 1'b1;
        for (int k = 0; k < nfr; k++) begin
            int   rem = clip - k * 512;
            int   fl  = (rem > 512) ? 512 : rem;
            logic lst = (k == nfr - 1);
            wait_valid();
            chk(out_id == id, "R4", "out_id", 64'(out_id), 64'(id));
            chk(out_sub_id == {id[4:0], 3'(k)}, "R4", "out_sub_id",
                64'(out_sub_id), 64'({id[4:0], 3'(k)}));
            chk(out_src == src + 64'(k * 512), "R5", "out_src", out_src, src + 64'(k * 512));
            chk(out_dst == dst + 64'(k * 512), "R5", "out_dst", out_dst, dst + 64'(k * 512));
            chk(out_len == 10'(fl), "R2", "out_len", 64'(out_len), 64'(fl));
            chk(out_last == lst, "R6", "out_last", 64'(out_last), 64'(lst));
            chk(out_prio == prio && out_func == func, "R6", "prio/func",
                64'({out_prio, out_func}), 64'({prio, func}));
            @(negedge clk);
        end
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        chk(in_ready == 1'b1, "R9", "in_ready after reset", 64'(in_ready), 64'd1);
        chk(out_valid == 1'b0, "R9", "out_valid after reset", 64'(out_valid), 64'd0);
    endtask

    task automatic t_basic();
        // R10 layout, two fragments, reserved bits set
        push(mk(64'h1000_0000, 64'h8000_0000, 1000, 8'd3, 1'b1, 8'h5a));
        expect_desc(64'h1000_0000, 64'h8000_0000, 1000, 8'd3, 1'b1, 8'h5a);
        // R4 top of ID window
        push(mk(64'h2000, 64'h3000, 512, 8'd31, 1'b0, 8'h01));
        expect_desc(64'h2000, 64'h3000, 512, 8'd31, 1'b0, 8'h01);
        // R2 remainder of one byte
        push(mk(64'h4000, 64'h5000, 513, 8'd0, 1'b0, 8'h02));
        expect_desc(64'h4000, 64'h5000, 513, 8'd0, 1'b0, 8'h02);
    endtask

    task automatic t_zero();
        push(mk(64'hA000, 64'hB000, 0, 8'd9, 1'b1, 8'h03));
        expect_desc(64'hA000, 64'hB000, 0, 8'd9, 1'b1, 8'h03);  // R7
        chk(out_valid == 1'b0, "R7", "single fragment only", 64'(out_valid), 64'd0);
    endtask

    task automatic t_clip();
        push(mk(64'h10_0000, 64'h20_0000, 5000, 8'd7, 1'b0, 8'h04));
        expect_desc(64'h10_0000, 64'h20_0000, 5000, 8'd7, 1'b0, 8'h04);  // R3
        chk(out_valid == 1'b0, "R3", "no ninth fragment", 64'(out_valid), 64'd0);
    endtask

    task automatic t_full();
        logic [7:0]  sid;
        logic [63:0] ssrc;
        out_ready = 1'b0;
        for (int i = 0; i < 4; i++) begin
            push(mk(64'h100 * (i + 1), 64'h9000 + 64'h100 * i, 600, 8'(10 + i), 1'b0, 8'(i)));
        end
        chk(in_ready == 1'b0, "R1", "in_ready with four held", 64'(in_ready), 64'd0);
        sid  = out_sub_id;
        ssrc = out_src;
        in_data  = mk(64'hDEAD, 64'hBEEF, 64, 8'd20, 1'b1, 8'hff);
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b0, "R1", "in_ready stays low", 64'(in_ready), 64'd0);
        chk(out_sub_id == sid && out_src == ssrc && out_valid, "R8", "stall hold",
            {out_sub_id, out_src[55:0]}, {sid, ssrc[55:0]});
        in_valid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            expect_desc(64'h100 * (i + 1), 64'h9000 + 64'h100 * i, 600, 8'(10 + i), 1'b0, 8'(i));
        end
        chk(out_valid == 1'b0, "R1", "word offered while full not taken", 64'(out_valid), 64'd0);
    endtask

    task automatic t_stream();
        fork
            begin
                for (int i = 0; i < 6; i++) begin
                    push(mk(64'h7000 + 64'h200 * i, 64'hC000 + 64'h200 * i, 512,
                            8'(40 + i), 1'(i), 8'(i + 100)));
                end
            end
            begin
                for (int i = 0; i < 6; i++) begin
                    expect_desc(64'h7000 + 64'h200 * i, 64'hC000 + 64'h200 * i, 512,
                                8'(40 + i), 1'(i), 8'(i + 100));  // R8 order, R1 same-edge
                end
            end
        join
        chk(out_valid == 1'b0, "R8", "stream drained", 64'(out_valid), 64'd0);
    endtask

    task automatic t_reset_mid();
        push(mk(64'h50000, 64'h60000, 2048, 8'd5, 1'b0, 8'h11));
        push(mk(64'h51000, 64'h61000, 700, 8'd6, 1'b0, 8'h12));
        out_ready = 1'b1;
        wait_valid();
        @(negedge clk);
        out_ready = 1'b0;
        rst_n     = 1'b0;
        @(negedge clk);
        rst_n     = 1'b1;
        chk(out_valid == 1'b0, "R9", "queue emptied", 64'(out_valid), 64'd0);
        chk(in_ready == 1'b1, "R9", "ready after reset", 64'(in_ready), 64'd1);
        push(mk(64'h70000, 64'h80000, 100, 8'd6, 1'b1, 8'h13));
        expect_desc(64'h70000, 64'h80000, 100, 8'd6, 1'b1, 8'h13);  // R9 restarts at 0
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL R8 watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_basic();
        t_zero();
        t_clip();
        t_full();
        t_stream();
        t_reset_mid();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule